// File: doc/BRIEF.md
# Nine-bit LCD command serializer

This block sends one display-panel command at a time over a write-only SPI mode 3 master port. A command is an 8-bit opcode plus up to two 8-bit parameters, handed over on a valid/ready handshake. Each byte is widened to a 9-bit word by a leading flag bit: 0 marks the opcode and 1 marks a parameter. The words are packed back to back, most significant bit first, into a stream of whole bytes. The unused tail of the last byte is filled with zeros.

Every command gets its own chip-select frame. Chip select goes low on acceptance. SCLK then runs from a half-period counter clocked by the system clock. Chip select goes high again one half-period after the final rising SCLK edge, and a one-cycle done pulse marks that moment. The block does not read from the panel, and it has no say over which commands are sent or in what order.

Top module: `lcd9_cmd_ser`

## Requirements
- R1: The first word on MOSI is flag bit 0 followed by the opcode, MSB first.
- R2: Each parameter word is flag bit 1 followed by the parameter byte, MSB first. `in_param0` is sent before `in_param1`.
- R3: A command with parameter count P (`in_pcount` = 0, 1 or 2) produces exactly 8*(P+2) rising SCLK edges within one chip-select frame.
- R4: The bits after the last 9-bit word and up to the end of the last byte are 0. There are 7, 6 or 5 of them for P = 0, 1 or 2.
- R5: SCLK idles high. MOSI changes only on a falling SCLK edge, so it is stable at every rising edge.
- R6: With half-period H = `HALF_DIV` system cycles (minimum 1), each SCLK low phase and each high phase lasts H cycles. The first falling edge comes H cycles after chip select goes low. Chip select goes high H cycles after the last rising edge.
- R7: Chip select is released after every command, so consecutive commands never share a frame.
- R8: A command with `in_pcount` = 3 is consumed without any bus activity and without a done pulse. `in_ready` stays high.
- R9: `in_ready` falls in the cycle after a legal command is accepted and stays low through the frame. `done` is high for exactly one cycle, the cycle in which chip select rises. `in_ready` returns high in the next cycle. While `in_ready` is low, `in_valid` has no effect.
- R10: In reset and right after it, `spi_cs_n` = 1, `spi_sclk` = 1, `spi_mosi` = 0, `done` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command offered |
| in_ready | output | 1 | Block can take a command |
| in_opcode | input | 8 | Command opcode |
| in_pcount | input | 2 | Number of parameters (0 to 2; 3 is illegal) |
| in_param0 | input | 8 | First parameter byte |
| in_param1 | input | 8 | Second parameter byte |
| spi_sclk | output | 1 | Serial clock, idle high |
| spi_mosi | output | 1 | Serial data to the panel |
| spi_cs_n | output | 1 | Chip select, active low |
| done | output | 1 | One-cycle pulse when chip select is released |

## Verification
The hardest case to reach is a command offered while a frame is still running. To create it, the bench keeps `in_valid` high with different contents for the whole frame. It then checks that the bits on the wire belong to the first command and that no second frame starts once `in_valid` is dropped. The padding bits and the edge timing are compared against values the bench derives arithmetically from the word index and bit position. This is done for every opcode with no parameters, and for swept and walking-bit parameter patterns with one and two parameters. The illegal parameter count is followed by a watch window in which the bus must stay idle.

// File: rtl/lcd9_pkg.sv
package lcd9_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_W     = BYTE_W + 1;
    localparam int MAX_PARAMS = 2;
    localparam int SLOTS      = MAX_PARAMS + 1;
    localparam int FRAME_W    = BYTE_W * (MAX_PARAMS + 2);
    localparam int BITCNT_W   = $clog2(FRAME_W + 1);
    localparam int PCNT_W     = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH
    } ser_state_e;

    typedef struct packed {
        ser_state_e           state;
        logic [FRAME_W-1:0]   shreg;
        logic [BITCNT_W-1:0]  left;
        logic                 sclk;
        logic                 mosi;
        logic                 cs_n;
        logic                 done;
        logic                 ready;
    } ser_regs_t;

endpackage

// File: rtl/lcd9_framer.sv
module lcd9_framer
    import lcd9_pkg::*;
(
    input  logic [BYTE_W-1:0]   opcode,
    input  logic [BYTE_W-1:0]   param0,
    input  logic [BYTE_W-1:0]   param1,
    input  logic [PCNT_W-1:0]   pcount,
    output logic [FRAME_W-1:0]  frame,
    output logic [BITCNT_W-1:0] nbits,
    output logic                legal
);

    logic [BYTE_W-1:0]  byte_in [SLOTS];
    logic [FRAME_W-1:0] slot    [SLOTS];

    assign byte_in[0] = opcode;
    assign byte_in[1] = param0;
    assign byte_in[2] = param1;

    // Each slot places its 9-bit word, left aligned, behind the earlier words
    for (genvar w = 0; w < SLOTS; w++) begin : g_slot
        localparam int SHIFT = w * WORD_W;
        logic [WORD_W-1:0] word;
        assign word    = {1'(w != 0), byte_in[w]};
        assign slot[w] = (PCNT_W'(w) <= pcount)
                       ? ({word, {(FRAME_W-WORD_W){1'b0}}} >> SHIFT)
                       : '0;
    end

    always_comb begin
        frame = '0;
        for (int w = 0; w < SLOTS; w++) begin
            frame = frame | slot[w];
        end
    end

    assign legal = (pcount <= PCNT_W'(MAX_PARAMS));
    assign nbits = BITCNT_W'((32'(pcount) + 32'd2) * BYTE_W);

endmodule

// File: rtl/lcd9_halftick.sv
module lcd9_halftick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(HALF_DIV - 1);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (!run || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R6: half-periods longer than one cycle never produce back-to-back ticks
    if (HALF_DIV > 1) begin : g_gap_chk
        p_tick_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
    end

endmodule

// File: rtl/lcd9_shift_fsm.sv
module lcd9_shift_fsm
    import lcd9_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                legal,
    input  logic [FRAME_W-1:0]  frame,
    input  logic [BITCNT_W-1:0] nbits,
    input  logic                tick,
    output logic                run,
    output logic                in_ready,
    output logic                sclk,
    output logic                mosi,
    output logic                cs_n,
    output logic                done
);

    ser_regs_t d, q;
    logic      launch;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        launch = 1'b0;
        if (q.done) begin
            d.ready = 1'b1;
        end
        case (q.state)
            ST_IDLE: begin
                if (in_valid && q.ready && legal) begin
                    d.state = ST_LEAD;
                    d.cs_n  = 1'b0;
                    d.ready = 1'b0;
                    d.shreg = frame;
                    d.left  = nbits;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    launch = 1'b1;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    d.sclk  = 1'b1;
                    d.state = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    if (q.left != '0) begin
                        launch = 1'b1;
                    end else begin
                        d.cs_n  = 1'b1;
                        d.done  = 1'b1;
                        d.state = ST_IDLE;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
        // Falling edge: present the next bit
        if (launch) begin
            d.sclk  = 1'b0;
            d.mosi  = q.shreg[FRAME_W-1];
            d.shreg = {q.shreg[FRAME_W-2:0], 1'b0};
            d.left  = q.left - 1'b1;
            d.state = ST_LOW;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.shreg <= '0;
            q.left  <= '0;
            q.sclk  <= 1'b1;
            q.mosi  <= 1'b0;
            q.cs_n  <= 1'b1;
            q.done  <= 1'b0;
            q.ready <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign run      = (q.state != ST_IDLE);
    assign in_ready = q.ready;
    assign sclk     = q.sclk;
    assign mosi     = q.mosi;
    assign cs_n     = q.cs_n;
    assign done     = q.done;

    // R5: clock parked high whenever the panel is deselected
    p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    // R5: data moves only together with a falling clock
    p_mosi_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> $fell(sclk));

    // R7: clock edges only inside a frame
    p_fall_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> !cs_n);

    // R9: done coincides with chip-select release
    p_done_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(cs_n));

    // R9: done is a single-cycle pulse followed by ready
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && in_ready));

    // R9: no acceptance while a frame is open
    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !in_ready);

endmodule

// File: rtl/lcd9_cmd_ser.sv
module lcd9_cmd_ser
    import lcd9_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_opcode,
    input  logic [1:0]  in_pcount,
    input  logic [7:0]  in_param0,
    input  logic [7:0]  in_param1,
    output logic        spi_sclk,
    output logic        spi_mosi,
    output logic        spi_cs_n,
    output logic        done
);

    logic [FRAME_W-1:0]  frame;
    logic [BITCNT_W-1:0] nbits;
    logic                legal;
    logic                run;
    logic                tick;

    lcd9_framer u_framer (
        .opcode (in_opcode),
        .param0 (in_param0),
        .param1 (in_param1),
        .pcount (in_pcount),
        .frame  (frame),
        .nbits  (nbits),
        .legal  (legal)
    );

    lcd9_halftick #(
        .HALF_DIV (HALF_DIV)
    ) u_halftick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    lcd9_shift_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .legal    (legal),
        .frame    (frame),
        .nbits    (nbits),
        .tick     (tick),
        .run      (run),
        .in_ready (in_ready),
        .sclk     (spi_sclk),
        .mosi     (spi_mosi),
        .cs_n     (spi_cs_n),
        .done     (done)
    );

    // R8: an illegal parameter count leaves the bus idle and stays ready
    p_drop_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_pcount == 2'd3) |=> (spi_cs_n && in_ready));

endmodule

// File: tb/lcd9_cmd_ser_tb.sv
`timescale 1ns/1ps
module lcd9_cmd_ser_tb;

    localparam int H = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_opcode = '0;
    logic [1:0] in_pcount = '0;
    logic [7:0] in_param0 = '0;
    logic [7:0] in_param1 = '0;
    logic       spi_sclk, spi_mosi, spi_cs_n, done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    lcd9_cmd_ser #(.HALF_DIV(H)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_opcode(in_opcode), .in_pcount(in_pcount),
        .in_param0(in_param0), .in_param1(in_param1),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected wire bit i, from word index and position inside the word
    function automatic logic [31:0] exp_frame(input logic [1:0] pc, input logic [7:0] op,
                                              input logic [7:0] p0, input logic [7:0] p1);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < 32; i++) begin
            int w;
            int pos;
            logic [7:0] b;
            w   = i / 9;
            pos = i % 9;
            b   = (w == 0) ? op : ((w == 1) ? p0 : p1);
            if (w <= int'(pc) && w <= 2) begin
                v[31-i] = (pos == 0) ? (w != 0) : b[8-pos];
            end
        end
        return v;
    endfunction

    task automatic run_cmd(input logic [7:0] op, input logic [1:0] pc,
                           input logic [7:0] p0, input logic [7:0] p1, input bit junk);
        int t, nr, nf, bad_time, ready_bad, tdone, nb, pad_bad;
        logic prev;
        logic [31:0] got, exp;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_opcode = op; in_pcount = pc; in_param0 = p0; in_param1 = p1;
        @(negedge clk);
        if (junk) begin
            in_opcode = ~op; in_pcount = 2'd0; in_param0 = ~p0;
        end else begin
            in_valid = 1'b0;
        end
        t = 0; nr = 0; nf = 0; bad_time = 0; ready_bad = 0; tdone = -1;
        got = '0; prev = 1'b1;
        while (t < 2*H*40) begin
            if (!prev && spi_sclk) begin
                if (nr < 32) got[31-nr] = spi_mosi;
                if (t != 2*H + 2*H*nr) bad_time++;
                nr++;
            end
            if (prev && !spi_sclk) begin
                if (t != H + 2*H*nf) bad_time++;
                nf++;
            end
            if (spi_cs_n) begin
                tdone = t;
                break;
            end
            if (in_ready || done) ready_bad++;
            prev = spi_sclk;
            t++;
            @(negedge clk);
        end
        nb  = 8 * (int'(pc) + 2);
        exp = exp_frame(pc, op, p0, p1);
        pad_bad = 0;
        for (int i = 9*(int'(pc)+1); i < nb; i++) if (got[31-i]) pad_bad++;
        check(got == exp, "R1/R2", "frame bits", got, exp);
        check(pad_bad == 0, "R4", "nonzero pad bits", pad_bad, 0);
        check(nr == nb, "R3", "rising edges", nr, nb);
        check(bad_time == 0 && nf == nb, "R5/R6", "edge timing errors", bad_time, 0);
        check(tdone == 2*H*nb + H, "R6", "cs release cycle", tdone, 2*H*nb + H);
        check(done && !in_ready && ready_bad == 0, "R9", "done/ready at release",
              {done, in_ready, 8'(ready_bad)}, {1'b1, 1'b0, 8'd0});
        if (junk) in_valid = 1'b0;
        @(negedge clk);
        check(!done && in_ready && spi_cs_n, "R9", "after done",
              {done, in_ready, spi_cs_n}, 3'b011);
        if (junk) begin
            int act;
            act = 0;
            repeat (4*H) begin
                @(negedge clk);
                if (!spi_cs_n) act++;
            end
            check(act == 0, "R9", "offer during frame started a frame", act, 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(spi_cs_n && spi_sclk && !spi_mosi && !done, "R10", "outputs in reset",
              {spi_cs_n, spi_sclk, spi_mosi, done}, 4'b1100);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready && spi_cs_n && spi_sclk && !spi_mosi, "R10", "after reset",
              {in_ready, spi_cs_n, spi_sclk, spi_mosi}, 4'b1110);

        // R1, R3, R4: every opcode without parameters
        for (int op = 0; op < 256; op++) run_cmd(8'(op), 2'd0, 8'h00, 8'h00, 1'b0);

        // R2: one parameter, swept values
        for (int k = 0; k < 64; k++) run_cmd(8'(k*37 + 5), 2'd1, 8'(k*53 ^ 8'hA5), 8'hFF, 1'b0);

        // R2: two parameters, walking ones and zeros in each byte
        for (int b = 0; b < 8; b++) begin
            run_cmd(8'hFF, 2'd2, 8'(1 << b), 8'h00, 1'b0);
            run_cmd(8'h00, 2'd2, 8'h00, 8'(1 << b), 1'b0);
            run_cmd(8'h5A, 2'd2, ~8'(1 << b), 8'hFF, 1'b0);
            run_cmd(8'hC3, 2'd2, 8'hFF, ~8'(1 << b), 1'b0);
        end

        // R8: illegal parameter count is dropped silently
        begin
            int act;
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1; in_opcode = 8'h29; in_pcount = 2'd3;
            in_param0 = 8'hFF; in_param1 = 8'hFF;
            @(negedge clk);
            in_valid = 1'b0;
            act = 0;
            repeat (8*H) begin
                if (!spi_cs_n || !spi_sclk || done || !in_ready) act++;
                @(negedge clk);
            end
            check(act == 0, "R8", "bus activity after illegal count", act, 0);
        end

        // R7, R9: back-to-back frames, with an offer held through one frame
        run_cmd(8'hB8, 2'd2, 8'hFF, 8'hF9, 1'b1);
        run_cmd(8'h11, 2'd0, 8'h00, 8'h00, 1'b0);
        run_cmd(8'hB0, 2'd1, 8'h16, 8'h00, 1'b1);
        run_cmd(8'h28, 2'd0, 8'h00, 8'h00, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule